// File: doc/BRIEF.md
# ATA Control-Block Register Interface

This block is the device-side register set that answers the control chip select of a parallel ATA style host bus. It decodes the three-bit register address. At address 6 a read returns the alternate status and a write loads the device control register. At address 7 a read returns a diagnostic byte that reports write-gate, head and drive-select state in active-low form. The block keeps the interrupt-pending flag and drives the interrupt line as a tristate signal, given as a level and a drive enable. It holds the high-order-byte flag that the command block uses for 48-bit addressing.

The soft-reset bit of the control register forces the busy bit of status. It holds for as long as the bit is set and for a configurable number of clocks after the bit is cleared. During that time any pending interrupt is discarded. Soft reset acts whichever drive is selected, so both drives on a shared cable reset together. Read data is given as a value and a per-bit drive enable. The command state machine supplies the core status byte, an interrupt-set pulse and a strobe that marks a read of the primary status register.

Top module: `ataCtlRegs`

## Requirements
- R1: A register access needs `csCtl` high. A read at `addr` 6 drives all eight bits of `rdData` (`rdDrive` = 8'hFF). A read at `addr` 7 drives bits 6..0 only (`rdDrive` = 8'h7F). Any other access leaves `rdDrive` at 0 and `rdData` at 0.
- R2: The alternate status read returns `coreStatus`, with bit 7 (busy) forced to 1 while soft reset is in effect. The read leaves a pending interrupt in place.
- R3: An `intSet` pulse sets the pending flag, which appears on `intrqLevel` in the next cycle. A `statusRead` pulse clears it. If both pulses come in the same cycle, the flag is set. After reset the flag is 0.
- R4: A write at `addr` 6 loads bit 7 as the high-order-byte flag (`hob`), bit 2 as soft reset and bit 1 as the active-low interrupt enable. Bits 6..3 and bit 0 have no effect. All three fields reset to 0.
- R5: Any write with `csCmd` high clears `hob` in the next cycle.
- R6: While the soft-reset bit is 1, status bit 7 reads 1 and the pending flag is held at 0. This happens whatever the values of `devSel` and `isDevice1`.
- R7: After soft reset is written back to 0, status bit 7 stays 1 for exactly `BUSY_DELAY` clock cycles, counted from the write edge. After that it follows `coreStatus[7]`.
- R8: `intrqDrive` is 1 only when the interrupt enable bit is 0 and `devSel` equals `isDevice1`. `intrqLevel` always carries the pending flag.
- R9: The diagnostic byte has bit 7 undriven. Bit 6 is `~writeGate` and bits 5..2 are `~headNum`. Bit 1 is 0 when `devSel` is 1, and bit 0 is 0 when `devSel` is 0.
- R10: A write at `addr` 7 changes nothing: `hob`, soft reset and the interrupt enable keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csCtl | input | 1 | Control block select, active high |
| csCmd | input | 1 | Command block select, active high |
| addr | input | 3 | Register address |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Read data value |
| rdDrive | output | 8 | Per-bit read data drive enable |
| coreStatus | input | 8 | Status byte from the command engine |
| writeGate | input | 1 | Media write in progress |
| headNum | input | 4 | Currently selected head number |
| devSel | input | 1 | Drive select bit from the device/head register |
| isDevice1 | input | 1 | This drive is configured as device 1 |
| intSet | input | 1 | Command engine raises an interrupt |
| statusRead | input | 1 | Primary status register is being read |
| intrqLevel | output | 1 | Interrupt line value |
| intrqDrive | output | 1 | Interrupt line drive enable |
| hob | output | 1 | High-order-byte flag for the command block |

## Verification
The assertions assume that the host never raises `hostRd` and `hostWr` in the same cycle. They also assume that a control write and a command write never coincide, and that `BUSY_DELAY` is at least 1. The bench holds each strobe for exactly one cycle and issues one access at a time, so it stays within these assumptions. It changes `devSel`, `isDevice1`, `writeGate` and `headNum` only between accesses, because the diagnostic byte and the interrupt enable are read combinationally from those inputs.

// File: rtl/ataCtlPkg.sv
package ataCtlPkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int HEAD_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_ALT_CTL = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_DIAG    = 3'd7;

  // control register field positions (host software depends on them)
  localparam int HOB_BIT  = 7;
  localparam int SRST_BIT = 2;
  localparam int NIEN_BIT = 1;

  // status busy bit position
  localparam int BUSY_BIT = 7;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic ctlWr;
    logic cmdWr;
    logic altRd;
    logic diagRd;
  } regStrobes_t;
endpackage

// File: rtl/ctlDecode.sv
module ctlDecode
  import ataCtlPkg::*;
(
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              csCtl,
  input  logic              csCmd,
  input  logic [ADDR_W-1:0] addr,
  output regStrobes_t       strb
);
  logic hitAltCtl;
  logic hitDiag;

  assign hitAltCtl = csCtl && (addr == ADDR_ALT_CTL);
  assign hitDiag   = csCtl && (addr == ADDR_DIAG);

  always_comb begin
    strb        = '0;
    strb.ctlWr  = hostWr && hitAltCtl;
    strb.cmdWr  = hostWr && csCmd;
    strb.altRd  = hostRd && hitAltCtl;
    strb.diagRd = hostRd && hitDiag;
  end
endmodule

// File: rtl/srstTimer.sv
module srstTimer #(
  parameter int BUSY_DELAY = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic srstHeld,
  output logic srstBusy
);
  localparam int CNT_W = $clog2(BUSY_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_DELAY);

  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (srstHeld) begin
      holdCnt <= CNT_LOAD;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign srstBusy = srstHeld || (holdCnt != '0);

  // R7
  busy_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(srstHeld) |-> srstBusy);

  // R7
  busy_countdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srstHeld && holdCnt > 1) |=> srstBusy);
endmodule

// File: rtl/ctlDatapath.sv
module ctlDatapath
  import ataCtlPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] coreStatus,
  input  logic              writeGate,
  input  logic [HEAD_W-1:0] headNum,
  input  logic              devSel,
  input  logic              isDevice1,
  input  logic              intSet,
  input  logic              statusRead,
  input  logic              srstBusy,
  output logic              srstHeld,
  output logic              hob,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rdDrive,
  output logic              intrqLevel,
  output logic              intrqDrive
);
  logic hobQ;
  logic srstQ;
  logic nIenQ;
  logic intPending;
  logic [DATA_W-1:0] altStatus;
  logic [DATA_W-1:0] diagByte;
  logic [HEAD_W-1:0] headInv;

  // control register; a command block write clears the high-order-byte flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hobQ  <= 1'b0;
      srstQ <= 1'b0;
      nIenQ <= 1'b0;
    end else if (strb.ctlWr) begin
      hobQ  <= wrData[HOB_BIT];
      srstQ <= wrData[SRST_BIT];
      nIenQ <= wrData[NIEN_BIT];
    end else if (strb.cmdWr) begin
      hobQ  <= 1'b0;
    end
  end

  // pending interrupt: soft reset discards it, a new request beats a status read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intPending <= 1'b0;
    end else if (srstBusy) begin
      intPending <= 1'b0;
    end else if (intSet) begin
      intPending <= 1'b1;
    end else if (statusRead) begin
      intPending <= 1'b0;
    end
  end

  always_comb begin
    altStatus           = coreStatus;
    altStatus[BUSY_BIT] = coreStatus[BUSY_BIT] | srstBusy;
  end

  for (genvar i = 0; i < HEAD_W; i++) begin : gHeadInv
    assign headInv[i] = ~headNum[i];
  end

  assign diagByte = {1'b0, ~writeGate, headInv, ~devSel, devSel};

  always_comb begin
    rdData  = '0;
    rdDrive = '0;
    if (strb.altRd) begin
      rdData  = altStatus;
      rdDrive = '1;
    end else if (strb.diagRd) begin
      rdData  = diagByte;
      rdDrive = {1'b0, {(DATA_W-1){1'b1}}};
    end
  end

  assign srstHeld   = srstQ;
  assign hob        = hobQ;
  assign intrqLevel = intPending;
  assign intrqDrive = !nIenQ && (devSel == isDevice1);

  // R2
  alt_read_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.altRd && intPending && !statusRead && !srstBusy) |=> intPending);

  // R3
  status_read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !intSet) |=> !intPending);

  // R3
  int_set_raises_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intSet && !srstBusy) |=> intPending);

  // R5
  cmd_write_clears_hob_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdWr && !strb.ctlWr) |=> !hob);

  // R6
  srst_forces_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    srstQ |-> srstBusy);

  // R6
  srst_drops_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    srstBusy |=> !intPending);

  // R9
  diag_top_bit_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.diagRd |-> !rdDrive[DATA_W-1]);

  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ctlWr && !strb.cmdWr) |=> ($stable(srstQ) && $stable(nIenQ) && $stable(hobQ)));
endmodule

// File: rtl/ataCtlRegs.sv
module ataCtlRegs
  import ataCtlPkg::*;
#(
  parameter int BUSY_DELAY = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csCtl,
  input  logic              csCmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rdDrive,
  input  logic [DATA_W-1:0] coreStatus,
  input  logic              writeGate,
  input  logic [HEAD_W-1:0] headNum,
  input  logic              devSel,
  input  logic              isDevice1,
  input  logic              intSet,
  input  logic              statusRead,
  output logic              intrqLevel,
  output logic              intrqDrive,
  output logic              hob
);
  regStrobes_t strb;
  logic srstHeld;
  logic srstBusy;

  ctlDecode uDecode (
    .hostRd (hostRd),
    .hostWr (hostWr),
    .csCtl  (csCtl),
    .csCmd  (csCmd),
    .addr   (addr),
    .strb   (strb)
  );

  srstTimer #(.BUSY_DELAY(BUSY_DELAY)) uTimer (
    .clk      (clk),
    .rstN     (rstN),
    .srstHeld (srstHeld),
    .srstBusy (srstBusy)
  );

  ctlDatapath uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .coreStatus (coreStatus),
    .writeGate  (writeGate),
    .headNum    (headNum),
    .devSel     (devSel),
    .isDevice1  (isDevice1),
    .intSet     (intSet),
    .statusRead (statusRead),
    .srstBusy   (srstBusy),
    .srstHeld   (srstHeld),
    .hob        (hob),
    .rdData     (rdData),
    .rdDrive    (rdDrive),
    .intrqLevel (intrqLevel),
    .intrqDrive (intrqDrive)
  );

  // R1
  single_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hostRd && hostWr));
endmodule

// File: tb/tb_ataCtlRegs.sv
`timescale 1ns/1ps
module tb_ataCtlRegs;
  localparam int BUSY_DELAY = 8;
  localparam int NVEC = 7;
  // fields: addr, writeGate, head, devSel, coreStatus, expected data, expected drive
  localparam logic [39:0] VEC [NVEC] = '{
    40'h6_0_0_0_50_50_FF,
    40'h6_0_0_0_D1_D1_FF,
    40'h5_0_0_0_50_00_00,
    40'h7_0_0_0_00_7E_7F,
    40'h7_1_F_1_00_01_7F,
    40'h7_0_9_1_00_59_7F,
    40'h7_1_5_0_00_2A_7F
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csCtl = 1'b0, csCmd = 1'b0, hostRd = 1'b0, hostWr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0, coreStatus = '0;
  logic       writeGate = 1'b0, devSel = 1'b0, isDevice1 = 1'b0;
  logic [3:0] headNum = '0;
  logic       intSet = 1'b0, statusRead = 1'b0;
  logic [7:0] rdData, rdDrive;
  logic       intrqLevel, intrqDrive, hob;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ataCtlRegs #(.BUSY_DELAY(BUSY_DELAY)) dut (
    .clk(clk), .rstN(rstN), .csCtl(csCtl), .csCmd(csCmd), .addr(addr),
    .hostRd(hostRd), .hostWr(hostWr), .wrData(wrData), .rdData(rdData),
    .rdDrive(rdDrive), .coreStatus(coreStatus), .writeGate(writeGate),
    .headNum(headNum), .devSel(devSel), .isDevice1(isDevice1),
    .intSet(intSet), .statusRead(statusRead), .intrqLevel(intrqLevel),
    .intrqDrive(intrqDrive), .hob(hob)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic ctl, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    csCtl = ctl; csCmd = !ctl; addr = a; wrData = d; hostWr = 1'b1;
    @(negedge clk);
    csCtl = 1'b0; csCmd = 1'b0; hostWr = 1'b0;
    #1;
  endtask

  task automatic pulse(logic doSet, logic doRead);
    @(negedge clk);
    intSet = doSet; statusRead = doRead;
    @(negedge clk);
    intSet = 1'b0; statusRead = 1'b0;
    #1;
  endtask

  task automatic startRead(logic [2:0] a);
    csCtl = 1'b1; addr = a; hostRd = 1'b1;
    #1;
  endtask

  task automatic endRead();
    csCtl = 1'b0; hostRd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int busyCount;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // reset state: R3 R4 R8 R1
    check("R3 reset pending", {7'b0, intrqLevel}, 8'h00);
    check("R4 reset hob", {7'b0, hob}, 8'h00);
    check("R8 reset enable drives", {7'b0, intrqDrive}, 8'h01);
    check("R1 idle no drive", rdDrive, 8'h00);

    // table of reads: R1 R2 R9
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      writeGate = VEC[i][32]; headNum = VEC[i][31:28];
      devSel = VEC[i][24]; coreStatus = VEC[i][23:16];
      startRead(VEC[i][38:36]);
      check("R1/R2/R9 table data", rdData, VEC[i][15:8]);
      check("R1/R9 table drive", rdDrive, VEC[i][7:0]);
      endRead();
    end
    devSel = 1'b0; coreStatus = 8'h50;

    // R1: no control select, no response
    @(negedge clk);
    addr = 3'd6; hostRd = 1'b1; #1;
    check("R1 no select", rdDrive, 8'h00);
    hostRd = 1'b0;

    // R4 / R5 high-order-byte flag
    regWrite(1'b1, 3'd6, 8'h80);
    check("R4 hob set", {7'b0, hob}, 8'h01);
    regWrite(1'b0, 3'd3, 8'h00);
    check("R5 cmd write clears hob", {7'b0, hob}, 8'h00);
    regWrite(1'b1, 3'd6, 8'h79);
    check("R4 unused bits hob", {7'b0, hob}, 8'h00);
    check("R4 unused bits enable", {7'b0, intrqDrive}, 8'h01);
    startRead(3'd6);
    check("R4 unused bits no srst", rdData, 8'h50);
    endRead();

    // R3 / R2 pending interrupt
    pulse(1'b1, 1'b0);
    check("R3 set", {7'b0, intrqLevel}, 8'h01);
    @(negedge clk);
    startRead(3'd6);
    @(negedge clk);
    endRead(); #1;
    check("R2 alt read keeps pending", {7'b0, intrqLevel}, 8'h01);
    pulse(1'b0, 1'b1);
    check("R3 status read clears", {7'b0, intrqLevel}, 8'h00);
    pulse(1'b1, 1'b1);
    check("R3 set wins", {7'b0, intrqLevel}, 8'h01);

    // R8 interrupt drive enable
    regWrite(1'b1, 3'd6, 8'h02);
    check("R8 disabled floats", {7'b0, intrqDrive}, 8'h00);
    check("R8 level still pending", {7'b0, intrqLevel}, 8'h01);
    regWrite(1'b1, 3'd6, 8'h00);
    check("R8 enabled drives", {7'b0, intrqDrive}, 8'h01);
    devSel = 1'b1; #1;
    check("R8 other drive selected", {7'b0, intrqDrive}, 8'h00);
    isDevice1 = 1'b1; #1;
    check("R8 device1 selected", {7'b0, intrqDrive}, 8'h01);

    // R10 writes to address 7 ignored
    regWrite(1'b1, 3'd7, 8'h86);
    check("R10 hob unchanged", {7'b0, hob}, 8'h00);
    check("R10 enable unchanged", {7'b0, intrqDrive}, 8'h01);
    startRead(3'd6);
    check("R10 no srst", rdData, 8'h50);
    endRead();

    // R6 soft reset on a non-selected drive
    isDevice1 = 1'b0;
    regWrite(1'b1, 3'd6, 8'h04);
    startRead(3'd6);
    check("R6 busy forced", rdData, 8'hD0);
    endRead();
    @(negedge clk); #1;
    check("R6 pending dropped", {7'b0, intrqLevel}, 8'h00);
    pulse(1'b1, 1'b0);
    check("R6 pending held low", {7'b0, intrqLevel}, 8'h00);

    // R7 busy hold after release
    regWrite(1'b1, 3'd6, 8'h00);
    busyCount = 0;
    for (int j = 0; j < 40; j++) begin
      startRead(3'd6);
      if (rdData[7]) busyCount++;
      endRead();
      @(negedge clk);
    end
    check("R7 busy hold cycles", 8'(busyCount), 8'(BUSY_DELAY));
    startRead(3'd6);
    check("R7 follows core", rdData, 8'h50);
    endRead();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule